// File: doc/BRIEF.md
# Hashed destination-address filter for Ethernet receive

The block decides whether a received Ethernet frame is passed on or dropped, based only on its 48-bit destination address. Two 64-bin hash tables are held, one for group (multicast) destinations and one for individual (unicast) destinations. Each table is four 16-bit words. Software-side logic programs a table by issuing a set command with an address. The block runs that address through a CRC-32 and sets the one bin that the top six CRC bits name.

On receive, the destination address is hashed the same way. The table is picked by the group bit of the address. The frame is accepted when the bin is set and rejected when it is clear. The broadcast address is always accepted. Because many addresses share a bin, an accept is only a coarse pass; a reject is final.

One serial CRC engine is shared by commands and receive requests. It advances one address bit per clock, so each request takes 48 clocks. Both tables can be cleared in one cycle, and any of the eight table words can be read at any time.

Top module: `eth_hash_filter`

## Requirements
- R1: After reset, all eight table words read as zero and done_o, accept_o and reject_o are low.
- R2: The hash is a CRC-32 with polynomial 0x04C11DB7, starting from all ones, with no final inversion. The address is fed first byte first (bits 47:40 are the first byte), each byte least-significant bit first.
- R3: CRC bits 31:30 select the table word (0 is word 0) and CRC bits 29:26 select the bit within it (0 is bit 0).
- R4: A set command strobed while idle sets exactly one bin. It goes in the group table when cmd_tbl_i is 1 and in the individual table when it is 0, and it is visible on the read port 49 clocks after the strobe edge.
- R5: A receive request uses the group table when address bit 40 (bit 0 of the first byte) is 1 and the individual table otherwise. It accepts when the selected bin is set and rejects otherwise.
- R6: The all-ones destination address is always accepted, even with empty tables.
- R7: done_o is a one-cycle pulse registered 48 clocks after the edge that took the receive strobe. accept_o and reject_o are high only with done_o, and exactly one of them is high.
- R8: Strobes arriving while a computation runs are ignored. When cmd_set_i and rx_valid_i arrive together, the command is taken and the receive request is dropped, so no done_o pulse follows.
- R9: clr_i synchronously zeroes both tables and wins over a set write landing in the same cycle.
- R10: rd_idx_i values 0 to 3 return individual words 0 to 3, and values 4 to 7 return group words 0 to 3, combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_set_i | input | 1 | Set-bin command strobe |
| cmd_tbl_i | input | 1 | Command target table: 1 group, 0 individual |
| cmd_addr_i | input | 48 | Address to hash for the command |
| clr_i | input | 1 | Synchronous clear of both tables |
| rx_valid_i | input | 1 | Receive destination strobe |
| rx_addr_i | input | 48 | Received destination address |
| done_o | output | 1 | Receive decision pulse |
| accept_o | output | 1 | Frame accepted (with done_o) |
| reject_o | output | 1 | Frame rejected (with done_o) |
| rd_idx_i | input | 3 | Table word select for readback |
| rd_data_o | output | 16 | Selected table word |

## Verification
The hardest situations to reach from the ports are a collision of requests in time: a strobe that lands while the engine is mid-computation, and a clear that lands on the very cycle a set write completes. The bench reaches them by counting negative edges from the strobe. It injects a command and a second receive request partway through a running computation. It raises clr_i for exactly the 48th edge after a set strobe. For the bin mapping, the bench searches addresses with its own CRC model to find ones that hash to bin 0 and bin 63, and then checks the bit positions directly.

// File: rtl/eth_hash_pkg.sv
package eth_hash_pkg;
  localparam int unsigned ADDR_W = 48;
  localparam int unsigned CRC_W  = 32;
  localparam logic [CRC_W-1:0] CRC_POLY = 32'h04C11DB7;
  localparam logic [CRC_W-1:0] CRC_INIT = '1;
  typedef enum logic {TBL_IND = 1'b0, TBL_GRP = 1'b1} tbl_sel_e;
endpackage

// File: rtl/eth_hash_crc.sv
module eth_hash_crc #(
  parameter int unsigned ADDR_W = eth_hash_pkg::ADDR_W,
  parameter int unsigned CRC_W  = eth_hash_pkg::CRC_W,
  parameter logic [CRC_W-1:0] POLY = eth_hash_pkg::CRC_POLY,
  parameter logic [CRC_W-1:0] INIT = eth_hash_pkg::CRC_INIT
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] bits_i,
  output logic              busy_o,
  output logic              last_o,
  output logic [CRC_W-1:0]  crc_nxt_o
);
  localparam int unsigned CNT_W = $clog2(ADDR_W + 1);

  logic [ADDR_W-1:0] sh_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CRC_W-1:0]  crc_q;
  logic              busy_q;
  logic              fb;

  always_comb begin
    fb        = crc_q[CRC_W-1] ^ sh_q[0];
    crc_nxt_o = {crc_q[CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
  end

  assign busy_o = busy_q;
  assign last_o = busy_q && (cnt_q == CNT_W'(ADDR_W - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      cnt_q  <= '0;
      crc_q  <= INIT;
      busy_q <= 1'b0;
    end else if (!busy_q) begin
      if (start_i) begin
        sh_q   <= bits_i;
        cnt_q  <= '0;
        crc_q  <= INIT;
        busy_q <= 1'b1;
      end
    end else begin
      crc_q <= crc_nxt_o;
      sh_q  <= sh_q >> 1;
      cnt_q <= cnt_q + 1'b1;
      if (last_o) busy_q <= 1'b0;
    end
  end
endmodule

// File: rtl/eth_hash_table.sv
module eth_hash_table #(
  parameter int unsigned NUM_REGS = 4,
  parameter int unsigned REG_W    = 16,
  localparam int unsigned RS_W    = $clog2(NUM_REGS),
  localparam int unsigned BS_W    = $clog2(REG_W)
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            clr_i,
  input  logic                            wr_i,
  input  logic [RS_W-1:0]                 reg_sel_i,
  input  logic [BS_W-1:0]                 bit_sel_i,
  output logic [NUM_REGS-1:0][REG_W-1:0]  words_o
);
  for (genvar r = 0; r < NUM_REGS; r++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  words_o[r] <= '0;
      else if (clr_i)                               words_o[r] <= '0;
      else if (wr_i && reg_sel_i == RS_W'(r))       words_o[r][bit_sel_i] <= 1'b1;
    end
  end
endmodule

// File: rtl/eth_hash_filter.sv
module eth_hash_filter #(
  parameter int unsigned ADDR_W   = eth_hash_pkg::ADDR_W,
  parameter int unsigned NUM_REGS = 4,
  parameter int unsigned REG_W    = 16,
  localparam int unsigned CRC_W   = eth_hash_pkg::CRC_W,
  localparam int unsigned RS_W    = $clog2(NUM_REGS),
  localparam int unsigned BS_W    = $clog2(REG_W),
  localparam int unsigned NUM_TBL = 2,
  localparam int unsigned RD_W    = RS_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_set_i,
  input  logic              cmd_tbl_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic              clr_i,
  input  logic              rx_valid_i,
  input  logic [ADDR_W-1:0] rx_addr_i,
  output logic              done_o,
  output logic              accept_o,
  output logic              reject_o,
  input  logic [RD_W-1:0]   rd_idx_i,
  output logic [REG_W-1:0]  rd_data_o
);
  import eth_hash_pkg::*;

  logic [ADDR_W-1:0] src_addr, ser_bits;
  logic              busy, last, start;
  logic [CRC_W-1:0]  crc_nxt;
  logic [RS_W-1:0]   reg_sel;
  logic [BS_W-1:0]   bit_sel;
  logic              op_set_q, op_bcast_q;
  tbl_sel_e          op_tbl_q;
  logic [NUM_TBL-1:0][NUM_REGS-1:0][REG_W-1:0] tbl_words;
  logic              hit;

  assign start    = (cmd_set_i | rx_valid_i) & ~busy;
  assign src_addr = cmd_set_i ? cmd_addr_i : rx_addr_i;

  // wire order: first byte first, each byte lsb first
  for (genvar k = 0; k < ADDR_W; k++) begin : g_ser
    assign ser_bits[k] = src_addr[ADDR_W - 8 - 8 * (k / 8) + (k % 8)];
  end

  eth_hash_crc #(.ADDR_W(ADDR_W), .CRC_W(CRC_W)) u_crc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .bits_i    (ser_bits),
    .busy_o    (busy),
    .last_o    (last),
    .crc_nxt_o (crc_nxt)
  );

  assign reg_sel = crc_nxt[CRC_W-1 -: RS_W];
  assign bit_sel = crc_nxt[CRC_W-1-RS_W -: BS_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_set_q   <= 1'b0;
      op_tbl_q   <= TBL_IND;
      op_bcast_q <= 1'b0;
    end else if (start) begin
      op_set_q   <= cmd_set_i;
      op_tbl_q   <= cmd_set_i ? tbl_sel_e'(cmd_tbl_i) : tbl_sel_e'(rx_addr_i[ADDR_W-8]);
      op_bcast_q <= &rx_addr_i;
    end
  end

  for (genvar t = 0; t < NUM_TBL; t++) begin : g_tbl
    eth_hash_table #(.NUM_REGS(NUM_REGS), .REG_W(REG_W)) u_tbl (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .clr_i     (clr_i),
      .wr_i      (last && op_set_q && (op_tbl_q == tbl_sel_e'(t))),
      .reg_sel_i (reg_sel),
      .bit_sel_i (bit_sel),
      .words_o   (tbl_words[t])
    );
  end

  assign hit = tbl_words[op_tbl_q][reg_sel][bit_sel];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o   <= 1'b0;
      accept_o <= 1'b0;
      reject_o <= 1'b0;
    end else begin
      done_o   <= last && !op_set_q;
      accept_o <= last && !op_set_q && (op_bcast_q || hit);
      reject_o <= last && !op_set_q && !(op_bcast_q || hit);
    end
  end

  assign rd_data_o = tbl_words[rd_idx_i[RD_W-1]][rd_idx_i[RS_W-1:0]];
endmodule

// File: rtl/eth_hash_filter_chk.sv
module eth_hash_filter_chk #(
  parameter int unsigned ADDR_W   = 48,
  parameter int unsigned NUM_REGS = 4,
  parameter int unsigned REG_W    = 16
) (
  input logic                           clk_i,
  input logic                           rst_ni,
  input logic                           cmd_set_i,
  input logic                           rx_valid_i,
  input logic [ADDR_W-1:0]              rx_addr_i,
  input logic                           clr_i,
  input logic                           busy_i,
  input logic                           done_o,
  input logic                           accept_o,
  input logic                           reject_o,
  input logic [NUM_REGS-1:0][REG_W-1:0] ind_words_i,
  input logic [NUM_REGS-1:0][REG_W-1:0] grp_words_i
);
  localparam int unsigned CNT_W = $clog2(ADDR_W + 2);

  logic [CNT_W-1:0] cnt_q;
  logic             run_q, bc_q;
  logic [2*NUM_REGS*REG_W-1:0] all_bits;

  assign all_bits = {grp_words_i, ind_words_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
      bc_q  <= 1'b0;
    end else if (rx_valid_i && !cmd_set_i && !busy_i) begin
      cnt_q <= '0;
      run_q <= 1'b1;
      bc_q  <= &rx_addr_i;
    end else if (done_o) begin
      run_q <= 1'b0;
    end else if (run_q) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  p_done_latency_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (run_q && cnt_q == CNT_W'(ADDR_W)));
  p_done_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_one_verdict_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (accept_o ^ reject_o));
  p_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> (!accept_o && !reject_o));
  p_bcast_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && bc_q) |-> accept_o);
  p_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(clr_i) |-> (all_bits == '0));
  p_one_bin_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(clr_i) |-> ($countones(all_bits) <= $countones($past(all_bits)) + 1));
endmodule

bind eth_hash_filter eth_hash_filter_chk #(
  .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS), .REG_W(REG_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cmd_set_i   (cmd_set_i),
  .rx_valid_i  (rx_valid_i),
  .rx_addr_i   (rx_addr_i),
  .clr_i       (clr_i),
  .busy_i      (busy),
  .done_o      (done_o),
  .accept_o    (accept_o),
  .reject_o    (reject_o),
  .ind_words_i (tbl_words[0]),
  .grp_words_i (tbl_words[1])
);

// File: tb/eth_hash_filter_tb.sv
module eth_hash_filter_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cmd_set_i = 1'b0, cmd_tbl_i = 1'b0, clr_i = 1'b0, rx_valid_i = 1'b0;
  logic [47:0] cmd_addr_i = '0, rx_addr_i = '0;
  logic        done_o, accept_o, reject_o;
  logic [2:0]  rd_idx_i = '0;
  logic [15:0] rd_data_o;

  int checks = 0, errors = 0, done_seen = 0;
  logic [15:0] m_tbl [2][4];

  always #5 clk_i = ~clk_i;

  eth_hash_filter u_dut (.*);

  always @(negedge clk_i) if (done_o) done_seen++;

  typedef struct packed {logic is_rx; logic tbl; logic [47:0] addr; logic must;} vec_t;
  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b1, 48'h01005E000001, 1'b0},
    '{1'b0, 1'b1, 48'h01005E0000FB, 1'b0},
    '{1'b0, 1'b0, 48'h020000000001, 1'b0},
    '{1'b0, 1'b0, 48'h00A0C9112233, 1'b0},
    '{1'b1, 1'b0, 48'h01005E000001, 1'b1},
    '{1'b1, 1'b0, 48'h01005E0000FB, 1'b1},
    '{1'b1, 1'b0, 48'h020000000001, 1'b1},
    '{1'b1, 1'b0, 48'h00A0C9112233, 1'b1},
    '{1'b1, 1'b0, 48'h01005E7F0000, 1'b0},
    '{1'b1, 1'b0, 48'h0A1B2C3D4E5F, 1'b0},
    '{1'b1, 1'b0, 48'h00005E000001, 1'b0},
    '{1'b1, 1'b0, 48'h030000000001, 1'b0},
    '{1'b1, 1'b0, 48'hFFFFFFFFFFFF, 1'b1}
  };

  function automatic logic [5:0] hidx(input logic [47:0] a);
    logic [31:0] c = 32'hFFFFFFFF;
    for (int k = 0; k < 48; k++) begin
      logic fb;
      fb = c[31] ^ a[40 - 8 * (k / 8) + (k % 8)];
      c = {c[30:0], 1'b0} ^ (fb ? 32'h04C11DB7 : 32'h0);
    end
    return c[31:26];
  endfunction

  function automatic logic m_accept(input logic [47:0] a);
    logic [5:0] ix = hidx(a);
    if (&a) return 1'b1;
    return m_tbl[a[40]][ix[5:4]][ix[3:0]];
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic m_set(input logic tbl, input logic [47:0] a);
    logic [5:0] ix = hidx(a);
    m_tbl[tbl][ix[5:4]][ix[3:0]] = 1'b1;
  endtask

  task automatic m_clear();
    for (int t = 0; t < 2; t++) for (int r = 0; r < 4; r++) m_tbl[t][r] = '0;
  endtask

  task automatic check_words(input string req);
    for (int i = 0; i < 8; i++) begin
      rd_idx_i = 3'(i);
      #1;
      check(req, rd_data_o, m_tbl[i / 4][i % 4]);
    end
  endtask

  // ends at the negedge 49 clocks after strobe negedge
  task automatic do_set(input logic tbl, input logic [47:0] a);
    @(negedge clk_i);
    cmd_set_i = 1'b1; cmd_tbl_i = tbl; cmd_addr_i = a;
    @(negedge clk_i);
    cmd_set_i = 1'b0;
    repeat (48) @(negedge clk_i);
    m_set(tbl, a);
  endtask

  task automatic do_rx(input logic [47:0] a, input logic exp, input string req);
    @(negedge clk_i);
    rx_valid_i = 1'b1; rx_addr_i = a;
    @(negedge clk_i);
    rx_valid_i = 1'b0;
    repeat (47) @(negedge clk_i);
    check("R7 early", done_o, 1'b0);
    @(negedge clk_i);
    check("R7 done", done_o, 1'b1);
    check(req, accept_o, exp);
    check(req, reject_o, !exp);
    @(negedge clk_i);
    check("R7 pulse", {done_o, accept_o, reject_o}, 3'b000);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog actual timeout expected finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [47:0] a;
    int base;
    m_clear();
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    check("R1 outputs", {done_o, accept_o, reject_o}, 3'b000);
    check_words("R1 tables");
    // R6 broadcast with empty tables
    do_rx(48'hFFFFFFFFFFFF, 1'b1, "R6 empty");

    // vector walk: R2 R4 R5 R10
    for (int v = 0; v < NV; v++) begin
      if (!VECS[v].is_rx) begin
        do_set(VECS[v].tbl, VECS[v].addr);
        check_words("R4 R10 set");
      end else begin
        logic e;
        e = m_accept(VECS[v].addr);
        if (VECS[v].must) check("R2 R5 model", e, 1'b1);
        do_rx(VECS[v].addr, e, "R5 R6 verdict");
      end
    end

    // R8 busy: set and rx mid-computation are dropped
    base = done_seen;
    @(negedge clk_i);
    rx_valid_i = 1'b1; rx_addr_i = 48'h020000000001;
    @(negedge clk_i);
    rx_valid_i = 1'b0;
    repeat (8) @(negedge clk_i);
    cmd_set_i = 1'b1; cmd_tbl_i = 1'b1; cmd_addr_i = 48'h01AABBCCDDEE;
    @(negedge clk_i);
    cmd_set_i = 1'b0;
    repeat (10) @(negedge clk_i);
    rx_valid_i = 1'b1; rx_addr_i = 48'hFFFFFFFFFFFF;
    @(negedge clk_i);
    rx_valid_i = 1'b0;
    repeat (100) @(negedge clk_i);
    check("R8 busy pulses", done_seen - base, 1);
    check_words("R8 busy no write");

    // R8 simultaneous command and receive: command wins, no done
    base = done_seen;
    @(negedge clk_i);
    cmd_set_i = 1'b1; cmd_tbl_i = 1'b0; cmd_addr_i = 48'h00112233AA55;
    rx_valid_i = 1'b1; rx_addr_i = 48'hFFFFFFFFFFFF;
    @(negedge clk_i);
    cmd_set_i = 1'b0; rx_valid_i = 1'b0;
    repeat (60) @(negedge clk_i);
    m_set(1'b0, 48'h00112233AA55);
    check("R8 same-cycle no done", done_seen - base, 0);
    check_words("R8 same-cycle write");

    // R9 clear landing on the set write edge
    @(negedge clk_i);
    cmd_set_i = 1'b1; cmd_tbl_i = 1'b1; cmd_addr_i = 48'h01005E0A0B0C;
    @(negedge clk_i);
    cmd_set_i = 1'b0;
    repeat (47) @(negedge clk_i);
    clr_i = 1'b1;
    @(negedge clk_i);
    clr_i = 1'b0;
    m_clear();
    check_words("R9 clear wins");
    do_rx(48'h01005E000001, 1'b0, "R9 R5 after clear");

    // R3 bin 0 -> individual word 0 bit 0; bin 63 -> word 3 bit 15
    a = 48'h020000000000;
    while (hidx(a) != 6'd0) a++;
    do_set(1'b0, a);
    rd_idx_i = 3'd0; #1;
    check("R3 bin0", rd_data_o, 16'h0001);
    a = 48'h020000000000;
    while (hidx(a) != 6'd63) a++;
    do_set(1'b1, a);
    rd_idx_i = 3'd7; #1;
    check("R3 R10 bin63 grp", rd_data_o, 16'h8000);
    do_rx(a, 1'b0, "R5 bin63 addr in individual table");
    check_words("R3 R10 final");

    // R9 plain clear
    @(negedge clk_i); clr_i = 1'b1;
    @(negedge clk_i); clr_i = 1'b0;
    m_clear();
    check_words("R9 clear");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule